// File: doc/BRIEF.md
# Multi-Cycle Four-Register Byte Processor

This block is a small multi-cycle processor core with an 8-bit datapath. It has four general registers, a 16-bit program counter and a zero flag and a carry flag. Instructions are one, two or three bytes long. The top nibble of the first byte selects the operation and the two lower bit pairs name the destination and source registers. Each instruction is fetched, decoded and executed over several clock cycles. The core uses one byte-wide memory port for code and data.

The memory port carries a 16-bit address, read data, write data and a write strobe. Read data is expected in the same cycle as the address, so the memory behaves as an asynchronous read. A registered 8-bit output holds the last byte sent by the output instruction. A halted output rises once the halt instruction has been fetched. After that the core stays parked, with the program counter still pointing at the halt byte, until reset.

Top module: `cpu_core`

## Requirements
- R1: While reset is active and just after it, mem_addr is 0x0000, mem_we is 0, io_out is 0x00 and halted is 0. Both flags are cleared, so a flag test run as the first instruction sees Z=0 and CY=0.
- R2: Bits [7:4] of the first byte hold the opcode, bits [3:2] hold Rd and bits [1:0] hold Rs. Code 00 selects R0, 01 selects R1, 10 selects R2 and 11 selects R3. Opcode 0xF (MOV) copies Rs into Rd.
- R3: ADD (0x9) sets CY to the carry out of Rd+Rs. SUB (0x8) computes Rd-Rs and sets CY to the borrow. DEC (0xB) computes Rd-1 and sets CY to the borrow. AND (0xA) computes Rd&Rs and clears CY. Each of the four writes its result to Rd and sets Z when the result is zero.
- R4: CLR (0xC) writes 0 to Rd, sets Z and clears CY. RL (0xD) rotates Rd left by one bit and copies the old bit 7 into CY. RRC (0xE) writes {CY, Rd[7:1]} to Rd and copies the old bit 0 into CY. All three set Z from the result.
- R5: MOV, LDI, LDA, STA, OUT and the three jumps leave Z and CY unchanged.
- R6: LDI (opcode 0x0, first byte 0000 Rd 00) is two bytes long. Its second byte is written to Rd, and execution resumes at the byte after the immediate.
- R7: LDA (0x2, first byte 0010 Rd 00) and STA (0x3, first byte 0011 00 Rs) carry a 16-bit address M in the next two bytes, low byte first. LDA writes the byte at M into Rd. STA drives M on mem_addr, drives Rs on mem_wdata and raises mem_we for exactly one cycle.
- R8: JMP (0x4), JZ (0x5) and JC (0x6) carry M the same way as LDA and STA. JMP always continues at M. JZ continues at M only when Z=1, and JC only when CY=1. A jump that is not taken continues at the instruction address plus 3.
- R9: OUT (first byte 0001 00 Rs) loads Rs into io_out. io_out holds that value until the next OUT.
- R10: HALT (first byte 0111 0000) raises halted. From then on, mem_addr stays at the address of the halt byte, mem_we stays 0 and nothing changes until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Byte address for fetch, operand and data access |
| mem_rdata | input | 8 | Byte read at mem_addr, valid in the same cycle |
| mem_wdata | output | 8 | Byte to be stored |
| mem_we | output | 1 | Store strobe, one cycle per store |
| io_out | output | 8 | Last byte sent by the output instruction |
| halted | output | 1 | High once the halt instruction has been fetched |

## Verification
In the execute cycle, the register file is read and written on the same clock edge, and the flags are updated on that edge too. Three cases fall into this cycle. The first is when Rd equals Rs. The second is RRC, which uses the old carry to build its result and produces the new carry in the same cycle. The third is a store that follows straight after an ALU write to the stored register. The bench provokes these cases with SUB R0,R0, with RRC run after a carry has been forced to 1, and with ALU results stored straight away. The register value and both flags are then judged. The register value is read back through stores to memory. The flags are decoded from which of four halt instructions the core parks on, using a jump-based probe.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DW   = 8;
  localparam int AW   = 2 * DW;
  localparam int NREG = 4;
  localparam int RSW  = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_LDI  = 4'h0, OP_OUT = 4'h1, OP_LDA = 4'h2, OP_STA = 4'h3,
    OP_JMP  = 4'h4, OP_JZ  = 4'h5, OP_JC  = 4'h6, OP_HALT = 4'h7,
    OP_SUB  = 4'h8, OP_ADD = 4'h9, OP_AND = 4'hA, OP_DEC = 4'hB,
    OP_CLR  = 4'hC, OP_RL  = 4'hD, OP_RRC = 4'hE, OP_MOV = 4'hF
  } opc_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_EXEC, ST_IMM, ST_ALO, ST_AHI, ST_MEM, ST_HALT
  } state_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          zf;
    logic          cf;
  } alu_res_t;

  // Opcodes whose first byte is followed by a two-byte address
  function automatic logic has_addr(opc_e op);
    return (op == OP_LDA) || (op == OP_STA) || (op == OP_JMP) ||
           (op == OP_JZ)  || (op == OP_JC);
  endfunction

  // Register-to-register group: upper half of the opcode space
  function automatic logic is_reg_op(opc_e op);
    return op[3];
  endfunction

  function automatic alu_res_t alu_eval(opc_e op, logic [DW-1:0] a,
                                        logic [DW-1:0] b, logic cin);
    alu_res_t   r;
    logic [DW:0] w;
    w     = '0;
    r.res = b;
    r.cf  = cin;
    case (op)
      OP_ADD: begin w = {1'b0, a} + {1'b0, b}; r.res = w[DW-1:0]; r.cf = w[DW]; end
      OP_SUB: begin w = {1'b0, a} - {1'b0, b}; r.res = w[DW-1:0]; r.cf = w[DW]; end
      OP_DEC: begin
        w = {1'b0, a} - {{DW{1'b0}}, 1'b1};
        r.res = w[DW-1:0];
        r.cf  = w[DW];
      end
      OP_AND: begin r.res = a & b; r.cf = 1'b0; end
      OP_CLR: begin r.res = '0; r.cf = 1'b0; end
      OP_RL:  begin r.res = {a[DW-2:0], a[DW-1]}; r.cf = a[DW-1]; end
      OP_RRC: begin r.res = {cin, a[DW-1:1]}; r.cf = a[0]; end
      default: begin r.res = b; r.cf = cin; end
    endcase
    r.zf = (r.res == '0);
    return r;
  endfunction
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NREG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ra_sel,
  input  logic [$clog2(N)-1:0] rb_sel,
  output logic [W-1:0]         ra,
  output logic [W-1:0]         rb
);
  localparam int SW = $clog2(N);

  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [SW-1:0] IDX = SW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  regs[g] <= '0;
      else if (we && waddr == IDX) regs[g] <= wdata;
    end
  end

  assign ra = regs[ra_sel];
  assign rb = regs[rb_sel];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
(
  input  opc_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          zf,
  output logic          cf
);
  alu_res_t r;
  always_comb r = alu_eval(op, a, b, cin);
  assign res = r.res;
  assign zf  = r.zf;
  assign cf  = r.cf;
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  rdata,
  input  logic           zf,
  input  logic           cf,
  output opc_e           opc,
  output logic [RSW-1:0] rd_sel,
  output logic [RSW-1:0] rs_sel,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic           rf_we,
  output logic           rf_from_mem,
  output logic           flag_we,
  output logic           io_we,
  output logic           halted,
  output logic           jump_taken,
  output logic [AW-1:0]  jump_dest
);
  state_e        st;
  logic [DW-1:0] ir, lo, hi;
  logic [AW-1:0] pc;
  opc_e          fop;

  assign fop    = opc_e'(rdata[DW-1:DW-4]);
  assign opc    = opc_e'(ir[DW-1:DW-4]);
  assign rd_sel = ir[2*RSW-1:RSW];
  assign rs_sel = ir[RSW-1:0];

  assign jump_dest  = {rdata, lo};
  assign jump_taken = (st == ST_AHI) &&
                      ((opc == OP_JMP) || (opc == OP_JZ && zf) || (opc == OP_JC && cf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_FETCH;
      pc <= '0;
      ir <= '0;
      lo <= '0;
      hi <= '0;
    end else begin
      case (st)
        ST_FETCH: begin
          ir <= rdata;
          if (fop == OP_HALT) begin
            st <= ST_HALT;
          end else begin
            pc <= pc + 1'b1;
            if (fop == OP_LDI)     st <= ST_IMM;
            else if (has_addr(fop)) st <= ST_ALO;
            else                   st <= ST_EXEC;
          end
        end
        ST_EXEC: st <= ST_FETCH;
        ST_IMM: begin
          pc <= pc + 1'b1;
          st <= ST_FETCH;
        end
        ST_ALO: begin
          lo <= rdata;
          pc <= pc + 1'b1;
          st <= ST_AHI;
        end
        ST_AHI: begin
          hi <= rdata;
          pc <= jump_taken ? jump_dest : pc + 1'b1;
          st <= (opc == OP_LDA || opc == OP_STA) ? ST_MEM : ST_FETCH;
        end
        ST_MEM:  st <= ST_FETCH;
        ST_HALT: st <= ST_HALT;
        default: st <= ST_FETCH;
      endcase
    end
  end

  assign mem_addr    = (st == ST_MEM) ? {hi, lo} : pc;
  assign mem_we      = (st == ST_MEM) && (opc == OP_STA);
  assign rf_we       = ((st == ST_EXEC) && is_reg_op(opc)) || (st == ST_IMM) ||
                       ((st == ST_MEM) && (opc == OP_LDA));
  assign rf_from_mem = (st == ST_IMM) || (st == ST_MEM);
  assign flag_we     = (st == ST_EXEC) && is_reg_op(opc) && (opc != OP_MOV);
  assign io_we       = (st == ST_EXEC) && (opc == OP_OUT);
  assign halted      = (st == ST_HALT);
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic [15:0]   mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic [7:0]    io_out,
  output logic          halted
);
  opc_e           opc;
  logic [RSW-1:0] rd_sel, rs_sel;
  logic           rf_we, rf_from_mem, flag_we, io_we;
  logic           jump_taken;
  logic [AW-1:0]  jump_dest;
  logic [DW-1:0]  rd_val, rs_val, alu_res, wb_data;
  logic           alu_z, alu_c;
  logic           zf_q, cf_q;
  logic [DW-1:0]  io_q;

  cpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdata(mem_rdata), .zf(zf_q), .cf(cf_q),
    .opc(opc), .rd_sel(rd_sel), .rs_sel(rs_sel), .mem_addr(mem_addr),
    .mem_we(mem_we), .rf_we(rf_we), .rf_from_mem(rf_from_mem),
    .flag_we(flag_we), .io_we(io_we), .halted(halted),
    .jump_taken(jump_taken), .jump_dest(jump_dest)
  );

  assign wb_data = rf_from_mem ? mem_rdata : alu_res;

  cpu_regfile #(.W(DW), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rd_sel), .wdata(wb_data),
    .ra_sel(rd_sel), .rb_sel(rs_sel), .ra(rd_val), .rb(rs_val)
  );

  cpu_alu u_alu (
    .op(opc), .a(rd_val), .b(rs_val), .cin(cf_q),
    .res(alu_res), .zf(alu_z), .cf(alu_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q <= 1'b0;
      cf_q <= 1'b0;
      io_q <= '0;
    end else begin
      if (flag_we) begin
        zf_q <= alu_z;
        cf_q <= alu_c;
      end
      if (io_we) io_q <= rs_val;
    end
  end

  assign mem_wdata = rs_val;
  assign io_out    = io_q;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  io_out,
  input logic        io_we,
  input logic        flag_we,
  input logic        zf,
  input logic        cf,
  input logic        jump_taken,
  input logic [15:0] jump_dest
);
  AST_HALT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr)); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we && !flag_we); // R10
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R7
  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({zf, cf})); // R5
  AST_OUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !io_we |=> $stable(io_out)); // R9
  AST_JUMP_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> mem_addr == $past(jump_dest)); // R8
endmodule

bind cpu_core cpu_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mem_we(mem_we),
  .mem_addr(mem_addr), .io_out(io_out), .io_we(io_we), .flag_we(flag_we),
  .zf(zf_q), .cf(cf_q), .jump_taken(jump_taken), .jump_dest(jump_dest)
);

// File: tb/cpu_core_test.sv
`timescale 1ns/1ps
module cpu_core_test;
  localparam int DUMP = 'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata, io_out;
  logic        mem_we, halted;
  logic        load = 1'b0;
  logic [7:0]  img [1024];
  logic [7:0]  mem [1024];
  int          p = 0;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  cpu_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .io_out(io_out), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 1024; i++) mem[i] <= img[i];
    end else if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 1024; i++) img[i] = 8'h00;
    p = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    img[p] = b;
    p++;
  endtask

  task automatic e_rr(input logic [3:0] op, input logic [1:0] rd, input logic [1:0] rs);
    emit({op, rd, rs});
  endtask

  task automatic e_ldi(input logic [1:0] rd, input logic [7:0] v);
    emit({4'h0, rd, 2'b00}); emit(v);
  endtask

  task automatic e_out(input logic [1:0] rs);
    emit({4'h1, 2'b00, rs});
  endtask

  task automatic e_lda(input logic [1:0] rd, input logic [15:0] a);
    emit({4'h2, rd, 2'b00}); emit(a[7:0]); emit(a[15:8]);
  endtask

  task automatic e_sta(input logic [15:0] a, input logic [1:0] rs);
    emit({4'h3, 2'b00, rs}); emit(a[7:0]); emit(a[15:8]);
  endtask

  task automatic e_jmp(input logic [3:0] op, input int a);
    emit({op, 4'h0}); emit(a[7:0]); emit(a[15:8]);
  endtask

  task automatic e_halt();
    emit(8'h70);
  endtask

  task automatic e_dump();
    for (int r = 0; r < 4; r++) e_sta(16'(DUMP + r), 2'(r));
  endtask

  // Flag probe: the core parks on base+6 (none), +7 (Z), +11 (CY), +12 (CY,Z)
  task automatic e_probe(output int base);
    base = p;
    e_jmp(4'h6, base + 8);
    e_jmp(4'h5, base + 7);
    e_halt(); e_halt();
    e_jmp(4'h5, base + 12);
    e_halt(); e_halt();
  endtask

  function automatic int probe_addr(input int base, input bit c, input bit z);
    return base + (c ? (z ? 12 : 11) : (z ? 7 : 6));
  endfunction

  task automatic run_prog();
    int cnt;
    rst_n = 1'b0;
    load  = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    while (!halted && cnt < 4000) begin
      @(negedge clk);
      cnt++;
    end
    if (!halted) chk("RUN", "halt reached", 0, 1);
  endtask

  task automatic t_reset();
    int base;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "mem_addr in reset", int'(mem_addr), 0);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    chk("R1", "io_out in reset", int'(io_out), 0);
    chk("R1", "halted in reset", int'(halted), 0);
    clear_img();
    e_probe(base);
    run_prog();
    chk("R1", "flags after reset", int'(mem_addr), probe_addr(base, 1'b0, 1'b0));
  endtask

  task automatic alu_case(input logic [3:0] op, input bit unary, input bit pre_c,
                          input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] exp_r, input bit ec, input bit ez,
                          input string req);
    int base;
    clear_img();
    if (pre_c) begin
      e_ldi(2'd3, 8'hFF); e_ldi(2'd0, 8'h01); e_rr(4'h9, 2'd3, 2'd0);
    end
    e_ldi(2'd1, a);
    e_ldi(2'd2, b);
    e_rr(op, 2'd1, unary ? 2'd0 : 2'd2);
    e_sta(16'(DUMP), 2'd1);
    e_probe(base);
    run_prog();
    chk(req, $sformatf("op %0h result", op), int'(mem[DUMP]), int'(exp_r));
    chk(req, $sformatf("op %0h flags", op), int'(mem_addr), probe_addr(base, ec, ez));
  endtask

  task automatic t_fields();
    int hp;
    clear_img();
    e_ldi(2'd0, 8'h70);
    e_ldi(2'd1, 8'h41);
    e_ldi(2'd2, 8'hB2);
    e_ldi(2'd3, 8'hC3);
    e_out(2'd1);
    e_rr(4'hF, 2'd1, 2'd3);
    e_rr(4'hF, 2'd2, 2'd0);
    e_dump();
    hp = p;
    e_halt();
    run_prog();
    chk("R2", "R0", int'(mem[DUMP]),   'h70);
    chk("R2", "R1", int'(mem[DUMP+1]), 'hC3);
    chk("R2", "R2", int'(mem[DUMP+2]), 'h70);
    chk("R2", "R3", int'(mem[DUMP+3]), 'hC3);
    chk("R6", "immediate skipped, halt addr", int'(mem_addr), hp);
    chk("R9", "io_out held", int'(io_out), 'h41);
  endtask

  task automatic t_mem();
    int base;
    clear_img();
    e_ldi(2'd0, 8'h5C);
    e_sta(16'h0123, 2'd0);
    e_ldi(2'd3, 8'hFF); e_ldi(2'd1, 8'h01); e_rr(4'h9, 2'd3, 2'd1);
    e_lda(2'd2, 16'h0123);
    e_out(2'd2);
    e_sta(16'(DUMP), 2'd2);
    e_probe(base);
    run_prog();
    chk("R7", "stored byte", int'(mem['h123]), 'h5C);
    chk("R7", "loaded byte", int'(mem[DUMP]), 'h5C);
    chk("R9", "io_out", int'(io_out), 'h5C);
    chk("R5", "flags kept over LDA/OUT/STA", int'(mem_addr), probe_addr(base, 1'b1, 1'b1));
  endtask

  task automatic t_jumps();
    clear_img();
    e_ldi(2'd0, 8'h12);
    e_rr(4'h8, 2'd0, 2'd0);
    e_jmp(4'h5, 8);
    e_ldi(2'd0, 8'hEE);
    e_ldi(2'd1, 8'h11);
    e_ldi(2'd2, 8'hFF);
    e_rr(4'h9, 2'd1, 2'd2);
    e_jmp(4'h6, 21);
    e_ldi(2'd1, 8'hEE);
    e_jmp(4'h4, 23);
    e_ldi(2'd1, 8'h11);
    e_ldi(2'd2, 8'h22);
    e_ldi(2'd3, 8'h11);
    e_rr(4'h9, 2'd3, 2'd2);
    e_jmp(4'h6, 34);
    e_jmp(4'h4, 36);
    e_ldi(2'd2, 8'hEE);
    e_dump();
    e_halt();
    run_prog();
    for (int r = 0; r < 4; r++)
      chk("R8", $sformatf("R%0d after branches", r), int'(mem[DUMP+r]), r * 'h11);
    chk("R8", "halt addr", int'(mem_addr), 48);
  endtask

  task automatic t_data();
    int hp;
    int ok;
    clear_img();
    e_ldi(2'd0, 8'h12);
    e_sta(16'h0100, 2'd0);
    e_lda(2'd1, 16'h0100);
    e_rr(4'hB, 2'd1, 2'd0);
    e_rr(4'hD, 2'd0, 2'd0);
    e_rr(4'h9, 2'd0, 2'd1);
    e_rr(4'hE, 2'd0, 2'd0);
    e_rr(4'h9, 2'd0, 2'd1);
    e_ldi(2'd2, 8'h76);
    e_rr(4'hA, 2'd2, 2'd0);
    e_rr(4'hF, 2'd3, 2'd2);
    e_rr(4'h9, 2'd3, 2'd1);
    e_rr(4'hC, 2'd0, 2'd0);
    e_out(2'd3);
    e_dump();
    hp = p;
    e_halt();
    run_prog();
    for (int r = 0; r < 4; r++)
      chk("R3", $sformatf("R%0d after data program", r), int'(mem[DUMP+r]), r * 'h11);
    chk("R7", "stored 0x100", int'(mem['h100]), 'h12);
    chk("R9", "io_out after data program", int'(io_out), 'h33);
    chk("R10", "halt addr", int'(mem_addr), hp);
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || mem_addr != 16'(hp) || mem_we) ok = 0;
    end
    chk("R10", "parked for 20 cycles", ok, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_fields();
    // R3 arithmetic and logic
    alu_case(4'h9, 0, 0, 8'h11, 8'hFF, 8'h10, 1, 0, "R3");
    alu_case(4'h9, 0, 0, 8'h80, 8'h80, 8'h00, 1, 1, "R3");
    alu_case(4'h8, 0, 0, 8'h05, 8'h07, 8'hFE, 1, 0, "R3");
    alu_case(4'h8, 0, 1, 8'h42, 8'h42, 8'h00, 0, 1, "R3");
    alu_case(4'hA, 0, 1, 8'hF0, 8'h0F, 8'h00, 0, 1, "R3");
    alu_case(4'hB, 1, 0, 8'h00, 8'h00, 8'hFF, 1, 0, "R3");
    alu_case(4'hB, 1, 1, 8'h01, 8'h00, 8'h00, 0, 1, "R3");
    // R4 clear and rotates
    alu_case(4'hC, 1, 1, 8'h5A, 8'h00, 8'h00, 0, 1, "R4");
    alu_case(4'hD, 1, 0, 8'h81, 8'h00, 8'h03, 1, 0, "R4");
    alu_case(4'hE, 1, 1, 8'h01, 8'h00, 8'h80, 1, 0, "R4");
    alu_case(4'hE, 1, 0, 8'h02, 8'h00, 8'h01, 0, 0, "R4");
    // R5 MOV and LDI keep flags
    alu_case(4'hF, 0, 1, 8'h00, 8'h77, 8'h77, 1, 1, "R5");
    t_mem();
    t_jumps();
    t_data();
    report();
    $finish;
  end
endmodule